// File: doc/BRIEF.md
# Simultaneous-Sampling ADC Readout Controller

This block runs a six-channel, 12-bit simultaneous-sampling converter that has a serial output, from the host side. When a start request is accepted, it raises the convert line for one divider period. It then generates the serial clock and collects one 16-clock slot for each enabled channel. Each slot is returned as a parallel 12-bit word, tagged with its channel index, a format flag (two's complement or straight binary) and a stale flag.

The converter always shifts out the samples it held at the previous convert edge. The controller therefore remembers whether the previous conversion was made under the same channel count and mode, and marks the words as stale when it was not. The channel-count select and the mode line are registered only when a start is accepted, and they stay fixed until the next accepted start. When the mode changes, an acquisition delay is inserted before the convert pulse.

For power control, the controller issues convert pulses while the serial clock is held low: two pulses request the light power-down state and four request the deep one. A single serial clock pulse wakes the converter again.

Top module: `simsamp_adc_ctrl`

## Requirements
- R1: A start request is accepted only while `busy_o` and `pwrdn_o` are both low. An accepted start gives exactly one convert pulse, high for CLK_DIV cycles. Start requests made while busy are ignored.
- R2: The 3-bit select code sets the number of enabled channels. Code 0 enables one channel, each higher code enables one more, and codes 5, 6 and 7 all enable six.
- R3: A frame gives exactly 16 serial clock rising edges per enabled channel. The serial clock and the convert line are never high together.
- R4: Words come out in channel order starting from channel 0. Each slot is received first bit first. The 12 result bits are slot bits 13 down to 2 (DATA_LSB = 2), where slot bit 15 is the first bit received.
- R5: Serial data is captured on the system clock edge at which the serial clock falls.
- R6: `word_stale_o` is high for every word of a frame whose previous conversion does not exist, or was made with a different enabled-channel count or mode. Such a conversion is absent after reset and after any power-down. Codes that enable the same channel count count as equal.
- R7: `adc_sel_o` and `adc_bip_o` change only when a start is accepted. Select or mode inputs applied while busy have no effect.
- R8: `word_signed_o` equals the mode line that was driven for the frame (1 = bipolar, two's complement).
- R9: If the accepted mode differs from the mode currently driven, the convert line rises ACQ_CYC cycles after acceptance. Otherwise it rises in the first cycle after acceptance.
- R10: `busy_o` is high from acceptance until the cycle after the last word's one-cycle `word_valid_o` pulse.
- R11: A light power-down request gives 2 convert pulses and a deep request gives 4, both with the serial clock held low. After the pulses `pwrdn_o` goes high, and start requests are ignored while it is high.
- R12: A wake request made while powered down gives exactly one serial clock pulse and no convert pulse, and clears `pwrdn_o`.
- R13: When requests arrive in the same idle cycle, deep power-down has priority over light power-down, and light power-down has priority over start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one conversion-and-readout frame |
| sel_code_i | input | 3 | Channel-count code for the next frame |
| bipolar_i | input | 1 | Mode for the next frame (1 = bipolar) |
| nap_req_i | input | 1 | Request light power-down |
| sleep_req_i | input | 1 | Request deep power-down |
| wake_req_i | input | 1 | Request wake from power-down |
| adc_conv_o | output | 1 | Convert line to the converter |
| adc_sck_o | output | 1 | Serial clock to the converter |
| adc_sdo_i | input | 1 | Serial data from the converter |
| adc_sel_o | output | 3 | Held channel-count select to the converter |
| adc_bip_o | output | 1 | Held mode line to the converter |
| busy_o | output | 1 | Frame, delay or power sequence in progress |
| pwrdn_o | output | 1 | Converter is in a power-down state |
| word_valid_o | output | 1 | One-cycle strobe for a captured word |
| word_data_o | output | 12 | Captured result bits |
| word_ch_o | output | 3 | Channel index of the word |
| word_signed_o | output | 1 | Word is two's complement |
| word_stale_o | output | 1 | Word does not belong to a matching previous conversion |

## Verification
The bench sweeps every select code under both modes, running two frames each. It checks the word count, the serial clock edge count and every data bit against a converter model. A decoder that failed to saturate would produce seven or eight words, and an off-by-one capture edge would shift every word by one bit. The stale rule is tested on the transitions that matter: after reset, after a mode change, after each power-down, and between codes 5, 6 and 7, which a raw code compare would wrongly flag. The bench also checks the exact acquisition delay, start and select changes injected during a frame and while powered down, and a start arriving together with a power-down request, which must not launch a frame.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;

    localparam int NAP_PULSES   = 2;
    localparam int SLEEP_PULSES = 4;
    localparam int PD_W         = 2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ACQ,
        ST_CONV_HI,
        ST_CONV_LO,
        ST_SHIFT,
        ST_PD_HI,
        ST_PD_LO,
        ST_ASLEEP,
        ST_WAKE_HI,
        ST_WAKE_LO
    } seq_state_e;

endpackage

// File: rtl/adcrd_div.sv
module adcrd_div #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    logic [DIV_W-1:0] cnt_d, cnt_q;

    assign tick_o = en_i && (cnt_q == DIV_W'(CLK_DIV - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (!en_i || tick_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/adcrd_chdec.sv
module adcrd_chdec #(
    parameter int NUM_CH = 6,
    parameter int SEL_W  = 3,
    parameter int NCH_W  = 3
) (
    input  logic [SEL_W-1:0] code_i,
    output logic [NCH_W-1:0] count_o
);
    always_comb begin
        if (int'(code_i) >= NUM_CH - 1) begin
            count_o = NCH_W'(NUM_CH);
        end else begin
            count_o = NCH_W'(int'(code_i) + 1);
        end
    end
endmodule

// File: rtl/adcrd_deser.sv
module adcrd_deser #(
    parameter int NUM_CH    = 6,
    parameter int SLOT_BITS = 16,
    parameter int DATA_BITS = 12,
    parameter int DATA_LSB  = 2,
    parameter int NCH_W     = 3,
    parameter int CH_W      = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear_i,
    input  logic                 sample_i,
    input  logic                 sdo_i,
    input  logic [NCH_W-1:0]     nch_i,
    input  logic                 signed_i,
    input  logic                 stale_i,
    output logic                 last_o,
    output logic                 word_valid_o,
    output logic [DATA_BITS-1:0] word_data_o,
    output logic [CH_W-1:0]      word_ch_o,
    output logic                 word_signed_o,
    output logic                 word_stale_o
);
    localparam int POS_W = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1;

    typedef struct packed {
        logic [POS_W-1:0]     pos;
        logic [CH_W-1:0]      ch;
        logic [DATA_BITS-1:0] acc;
        logic                 valid;
        logic [DATA_BITS-1:0] data;
        logic [CH_W-1:0]      wch;
        logic                 sgn;
        logic                 stl;
    } des_t;

    des_t d, q;
    logic slot_end;

    assign slot_end = sample_i && (q.pos == POS_W'(SLOT_BITS - 1));
    assign last_o   = slot_end && (int'(q.ch) == int'(nch_i) - 1);

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        // place each received bit by its position inside the slot
        for (int b = 0; b < DATA_BITS; b++) begin
            if (sample_i && (int'(q.pos) == SLOT_BITS - 1 - DATA_LSB - b)) begin
                d.acc[b] = sdo_i;
            end
        end
        if (clear_i) begin
            d.pos = '0;
            d.ch  = '0;
        end else if (slot_end) begin
            d.pos   = '0;
            d.ch    = q.ch + 1'b1;
            d.valid = 1'b1;
            d.data  = d.acc;
            d.wch   = q.ch;
            d.sgn   = signed_i;
            d.stl   = stale_i;
        end else if (sample_i) begin
            d.pos = q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign word_valid_o  = q.valid;
    assign word_data_o   = q.data;
    assign word_ch_o     = q.wch;
    assign word_signed_o = q.sgn;
    assign word_stale_o  = q.stl;

    // R10: each word strobe lasts exactly one cycle
    p_word_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |=> !word_valid_o);

    // R2: a delivered channel index never reaches the channel count
    p_ch_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |-> (int'(word_ch_o) < NUM_CH));
endmodule

// File: rtl/simsamp_adc_ctrl.sv
module simsamp_adc_ctrl
    import adcrd_pkg::*;
#(
    parameter int CLK_DIV   = 4,
    parameter int ACQ_CYC   = 16,
    parameter int NUM_CH    = 6,
    parameter int SLOT_BITS = 16,
    parameter int DATA_BITS = 12,
    parameter int DATA_LSB  = 2,
    localparam int SEL_W    = $clog2(NUM_CH),
    localparam int CH_W     = $clog2(NUM_CH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [SEL_W-1:0]     sel_code_i,
    input  logic                 bipolar_i,
    input  logic                 nap_req_i,
    input  logic                 sleep_req_i,
    input  logic                 wake_req_i,
    output logic                 adc_conv_o,
    output logic                 adc_sck_o,
    input  logic                 adc_sdo_i,
    output logic [SEL_W-1:0]     adc_sel_o,
    output logic                 adc_bip_o,
    output logic                 busy_o,
    output logic                 pwrdn_o,
    output logic                 word_valid_o,
    output logic [DATA_BITS-1:0] word_data_o,
    output logic [CH_W-1:0]      word_ch_o,
    output logic                 word_signed_o,
    output logic                 word_stale_o
);
    localparam int NCH_W = $clog2(NUM_CH + 1);
    localparam int ACQ_W = $clog2(ACQ_CYC + 1);

    typedef struct packed {
        seq_state_e       st;
        logic             sck;
        logic [ACQ_W-1:0] acq;
        logic [PD_W-1:0]  pd_left;
        logic [SEL_W-1:0] sel;
        logic             bip;
        logic [NCH_W-1:0] nch;
        logic             have_prev;
        logic             stale;
    } ctl_t;

    ctl_t d, q;
    logic             tick;
    logic             div_en;
    logic             sample;
    logic             frame_last;
    logic [NCH_W-1:0] dec_cnt;

    assign div_en = (q.st == ST_CONV_HI) || (q.st == ST_CONV_LO) || (q.st == ST_SHIFT) ||
                    (q.st == ST_PD_HI)   || (q.st == ST_PD_LO)   ||
                    (q.st == ST_WAKE_HI) || (q.st == ST_WAKE_LO);
    assign sample = (q.st == ST_SHIFT) && tick && q.sck;

    adcrd_div #(.CLK_DIV(CLK_DIV)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (div_en),
        .tick_o (tick)
    );

    adcrd_chdec #(.NUM_CH(NUM_CH), .SEL_W(SEL_W), .NCH_W(NCH_W)) u_chdec (
        .code_i  (sel_code_i),
        .count_o (dec_cnt)
    );

    adcrd_deser #(
        .NUM_CH   (NUM_CH),
        .SLOT_BITS(SLOT_BITS),
        .DATA_BITS(DATA_BITS),
        .DATA_LSB (DATA_LSB),
        .NCH_W    (NCH_W),
        .CH_W     (CH_W)
    ) u_deser (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (q.st == ST_IDLE),
        .sample_i     (sample),
        .sdo_i        (adc_sdo_i),
        .nch_i        (q.nch),
        .signed_i     (q.bip),
        .stale_i      (q.stale),
        .last_o       (frame_last),
        .word_valid_o (word_valid_o),
        .word_data_o  (word_data_o),
        .word_ch_o    (word_ch_o),
        .word_signed_o(word_signed_o),
        .word_stale_o (word_stale_o)
    );

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (!word_valid_o) begin
                    if (sleep_req_i) begin
                        d.st        = ST_PD_HI;
                        d.pd_left   = PD_W'(SLEEP_PULSES - 1);
                        d.have_prev = 1'b0;
                    end else if (nap_req_i) begin
                        d.st        = ST_PD_HI;
                        d.pd_left   = PD_W'(NAP_PULSES - 1);
                        d.have_prev = 1'b0;
                    end else if (start_i) begin
                        d.sel       = sel_code_i;
                        d.bip       = bipolar_i;
                        d.nch       = dec_cnt;
                        d.stale     = !q.have_prev || (dec_cnt != q.nch) || (bipolar_i != q.bip);
                        d.have_prev = 1'b1;
                        if (bipolar_i != q.bip) begin
                            d.st  = ST_ACQ;
                            d.acq = ACQ_W'(ACQ_CYC - 1);
                        end else begin
                            d.st = ST_CONV_HI;
                        end
                    end
                end
            end
            ST_ACQ: begin
                if (q.acq == '0) begin
                    d.st = ST_CONV_HI;
                end else begin
                    d.acq = q.acq - 1'b1;
                end
            end
            ST_CONV_HI: if (tick) d.st = ST_CONV_LO;
            ST_CONV_LO: begin
                if (tick) begin
                    d.st  = ST_SHIFT;
                    d.sck = 1'b0;
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    d.sck = !q.sck;
                    if (q.sck && frame_last) begin
                        d.st = ST_IDLE;
                    end
                end
            end
            ST_PD_HI: if (tick) d.st = ST_PD_LO;
            ST_PD_LO: begin
                if (tick) begin
                    if (q.pd_left == '0) begin
                        d.st = ST_ASLEEP;
                    end else begin
                        d.pd_left = q.pd_left - 1'b1;
                        d.st      = ST_PD_HI;
                    end
                end
            end
            ST_ASLEEP:  if (wake_req_i) d.st = ST_WAKE_HI;
            ST_WAKE_HI: if (tick) d.st = ST_WAKE_LO;
            ST_WAKE_LO: if (tick) d.st = ST_IDLE;
            default:    d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st        <= ST_IDLE;
            q.sck       <= 1'b0;
            q.acq       <= '0;
            q.pd_left   <= '0;
            q.sel       <= '0;
            q.bip       <= 1'b0;
            q.nch       <= NCH_W'(1);
            q.have_prev <= 1'b0;
            q.stale     <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign adc_conv_o = (q.st == ST_CONV_HI) || (q.st == ST_PD_HI);
    assign adc_sck_o  = ((q.st == ST_SHIFT) && q.sck) || (q.st == ST_WAKE_HI);
    assign adc_sel_o  = q.sel;
    assign adc_bip_o  = q.bip;
    assign pwrdn_o    = (q.st == ST_ASLEEP);
    assign busy_o     = ((q.st != ST_IDLE) && (q.st != ST_ASLEEP)) || word_valid_o;

    // R3: convert and serial clock are never high together
    p_conv_sck_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(adc_conv_o && adc_sck_o));

    // R7: the select and mode lines hold while a frame or sequence runs
    p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($stable(adc_sel_o) && $stable(adc_bip_o)));

    // R11: the converter lines stay quiet while powered down
    p_pd_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pwrdn_o |-> (!adc_conv_o && !adc_sck_o && !busy_o));

    // R1: a convert pulse only starts while the block reports busy
    p_conv_in_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_conv_o) |-> busy_o);
endmodule

// File: tb/simsamp_adc_ctrl_tb.sv
module simsamp_adc_ctrl_tb;
    localparam int DIV   = 2;
    localparam int ACQ   = 5;
    localparam int NCH   = 6;
    localparam int SLOT  = 16;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n, start, nap, sleep_r, wake, bip, sdo;
    logic [2:0]  sel;
    logic        conv, sck, adc_bip, busy, pwrdn, wv, wsgn, wstl;
    logic [2:0]  adc_sel, wch;
    logic [11:0] wdata;

    simsamp_adc_ctrl #(.CLK_DIV(DIV), .ACQ_CYC(ACQ)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .sel_code_i(sel), .bipolar_i(bip),
        .nap_req_i(nap), .sleep_req_i(sleep_r), .wake_req_i(wake),
        .adc_conv_o(conv), .adc_sck_o(sck), .adc_sdo_i(sdo), .adc_sel_o(adc_sel),
        .adc_bip_o(adc_bip), .busy_o(busy), .pwrdn_o(pwrdn), .word_valid_o(wv),
        .word_data_o(wdata), .word_ch_o(wch), .word_signed_o(wsgn), .word_stale_o(wstl)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // converter model: samples held at each convert edge, shifted out at the next frame
    logic [11:0] held [NCH];
    logic [11:0] outs [NCH];
    int kconv = 0, bidx = 0, conv_rises = 0, sck_rises = 0;

    function automatic logic [11:0] pat(input int k, input int c);
        if (k % 5 == 3) return 12'hFFF;
        if (k % 5 == 4) return 12'h000;
        return 12'((k * 1237 + c * 389 + 90) % 4096);
    endfunction

    initial begin
        sdo = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            held[c] = '0;
            outs[c] = '0;
        end
    end

    always @(posedge conv) begin
        for (int c = 0; c < NCH; c++) begin
            outs[c] = held[c];
            held[c] = pat(kconv, c);
        end
        kconv++;
        conv_rises++;
        bidx = 0;
    end

    always @(posedge sck) begin
        logic [15:0] w;
        int c, j;
        c = bidx / SLOT;
        j = bidx % SLOT;
        if (c < NCH) w = {2'b10, outs[c], 2'b01};
        else         w = 16'h0000;
        sdo <= w[15 - j];
        bidx++;
        sck_rises++;
    end

    // expected-state tracking and word monitor
    bit have_m = 0, pbip_m = 0, lbip_m = 0, exp_stale = 1, exp_bip = 0;
    int pnch_m = 0, widx = 0, words = 0;

    always @(negedge clk) begin
        if (rst_n && wv) begin
            chk(int'(wch) == widx, "R4 channel order", int'(wch), widx);
            if (!exp_stale && widx < NCH)
                chk(wdata == outs[widx], "R4 R5 word data", int'(wdata), int'(outs[widx]));
            chk(wsgn == exp_bip, "R8 format flag", int'(wsgn), int'(exp_bip));
            chk(wstl == exp_stale, "R6 stale flag", int'(wstl), int'(exp_stale));
            widx++;
            words++;
        end
    end

    task automatic run_frame(input int s, input bit b, input bit poke);
        int n, d, h, t;
        bit acq_exp;
        n = (s >= NCH - 1) ? NCH : s + 1;
        acq_exp   = (b != lbip_m);
        exp_stale = !have_m || (n != pnch_m) || (b != pbip_m);
        have_m = 1; pnch_m = n; pbip_m = b; lbip_m = b; exp_bip = b;
        widx = 0; words = 0; conv_rises = 0; sck_rises = 0;
        @(negedge clk); sel = 3'(s); bip = b; start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy == 1'b1, "R10 busy after accept", int'(busy), 1);
        d = 0;
        while (!conv && d < ACQ + 10) begin @(negedge clk); d++; end
        chk(d == (acq_exp ? ACQ : 0), "R9 convert delay", d, acq_exp ? ACQ : 0);
        h = 0;
        while (conv && h < 100) begin @(negedge clk); h++; end
        chk(h == DIV, "R1 convert width", h, DIV);
        if (poke) begin
            repeat (7) @(negedge clk);
            start = 1'b1; sel = ~sel; bip = ~bip;
            @(negedge clk);
            start = 1'b0; sel = 3'(s); bip = b;
        end
        t = 0;
        while (busy && t < 3000) begin @(negedge clk); t++; end
        chk(words == n, "R2 words per frame", words, n);
        chk(sck_rises == SLOT * n, "R3 serial clock edges", sck_rises, SLOT * n);
        chk(conv_rises == 1, "R1 single convert per frame", conv_rises, 1);
        chk(adc_sel == 3'(s), "R7 select held", int'(adc_sel), s);
        chk(adc_bip == b, "R7 mode held", int'(adc_bip), int'(b));
    endtask

    task automatic pd_cmd(input bit deep, input bit with_start);
        int t, cr;
        conv_rises = 0; sck_rises = 0; words = 0;
        @(negedge clk);
        if (deep) sleep_r = 1'b1; else nap = 1'b1;
        start = with_start;
        @(negedge clk); sleep_r = 1'b0; nap = 1'b0; start = 1'b0;
        t = 0;
        while (!pwrdn && t < 500) begin @(negedge clk); t++; end
        chk(conv_rises == (deep ? 4 : 2), "R11 power-down pulses", conv_rises, deep ? 4 : 2);
        chk(sck_rises == 0, "R11 serial clock idle", sck_rises, 0);
        if (with_start) begin
            repeat (4) @(negedge clk);
            chk(words == 0, "R13 power-down beats start", words, 0);
        end
        have_m = 0;
        cr = conv_rises;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (10) @(negedge clk);
        chk(conv_rises == cr, "R11 start ignored while down", conv_rises, cr);
        chk(pwrdn == 1'b1, "R11 stays powered down", int'(pwrdn), 1);
        chk(busy == 1'b0, "R11 not busy while down", int'(busy), 0);
        @(negedge clk); wake = 1'b1;
        @(negedge clk); wake = 1'b0;
        chk(pwrdn == 1'b0, "R12 wake clears power-down", int'(pwrdn), 0);
        t = 0;
        while (busy && t < 100) begin @(negedge clk); t++; end
        chk(sck_rises == 1, "R12 one wake pulse", sck_rises, 1);
        chk(conv_rises == cr, "R12 no convert on wake", conv_rises, cr);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; nap = 1'b0; sleep_r = 1'b0; wake = 1'b0;
        bip = 1'b0; sel = 3'd0;
        repeat (5) @(negedge clk);
        chk(conv == 1'b0, "R1 reset convert low", int'(conv), 0);
        chk(sck == 1'b0, "R3 reset clock low", int'(sck), 0);
        chk(busy == 1'b0, "R10 reset not busy", int'(busy), 0);
        chk(wv == 1'b0, "R10 reset no word", int'(wv), 0);
        chk(pwrdn == 1'b0, "R11 reset awake", int'(pwrdn), 0);
        chk(adc_sel == 3'd0, "R7 reset select", int'(adc_sel), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int b = 0; b < 2; b++) begin
            for (int s = 0; s < 8; s++) begin
                run_frame(s, bit'(b), 1'b0);
                run_frame(s, bit'(b), (s == 3));
            end
        end
        pd_cmd(1'b0, 1'b0);
        run_frame(5, 1'b1, 1'b0);
        run_frame(5, 1'b1, 1'b0);
        pd_cmd(1'b1, 1'b0);
        run_frame(2, 1'b1, 1'b0);
        run_frame(2, 1'b0, 1'b1);
        pd_cmd(1'b0, 1'b1);
        run_frame(6, 1'b0, 1'b0);
        run_frame(7, 1'b0, 1'b0);
        chk(exp_stale == 1'b0, "R6 codes 6 and 7 match", int'(exp_stale), 0);
        run_frame(4, 1'b0, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule